// File: doc/BRIEF.md
# Cascadable Down-Counting Interval Timer

This block is a 13-bit interval timer programmed through a single 16-bit control word. Software writes the word to pick a tick source, start or freeze the count and load a start value. On each tick the count drops by one. When a nonzero count runs out, the block raises a one-cycle interrupt and reloads the last nonzero value written, so it produces a periodic interrupt for as long as counting is on.

There are two tick sources. The first is a half-rate enable that toggles on every system clock. The second is an external tick input, meant to be driven by the output of a frame counter so that the two counters act as one longer chain. Writing a count of zero parks the counter without raising an interrupt. Software can use this to stop the timer after a single pass.

The top bit of the word turns the timer on, and it can only be turned off. Once software clears it, later writes have no effect and reads return zero until reset, so the address can serve another purpose.

Top module: `cascade_down_timer`

## Requirements
- R1: After reset the readback is 0x8000: timer on (bit 15 = 1), counting off (bit 14 = 0), half-rate source (bit 13 = 0), count 0 (bits 12:0). The interrupt is low.
- R2: With the half-rate source, a tick occurs every second system clock. A write of 0xC008 gives one interrupt every 16 system clocks.
- R3: While bit 14 is 0, the count holds its value.
- R4: With bit 13 = 1, the count drops only in cycles where `cascade_tick` is high.
- R5: When a tick finds the count at 1, the next count is the last nonzero value written, and the interrupt is raised together with that reload.
- R6: Writing a count of 0 raises no interrupt, and the count stays 0 until the next write.
- R7: The interrupt is high for one clock per expiry and only in the cycle after an expiring tick.
- R8: Writing bit 15 = 0 turns the timer off. While it is off, every later write is ignored, including writes that set bit 15, until reset.
- R9: While the timer is off, the readback is 0 and the interrupt stays low.
- R10: A write in the same cycle as an expiring tick wins. The count takes the written value and that expiry raises no interrupt.
- R11: While the timer is on, the readback is {bit 15 on, bit 14 run, bit 13 source, bits 12:0 current count}. The count is written in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| cascade_tick | input | 1 | External tick, used when bit 13 is set |
| rd_data | output | 16 | Readback of the control word with the live count |
| irq | output | 1 | One-cycle interrupt pulse on expiry |

## Verification
The two functions that can fall in the same cycle are a software write and the tick that takes the count from 1 to its reload value. To provoke this, the bench selects the external source, holds `cascade_tick` high and loads a count of 1, so that every cycle is an expiry. It then issues a new write. It judges the result by checking that the interrupt stays low in the following cycle and that the readback holds the written count rather than the reload. Random writes mixed with random tick patterns also meet this collision. A cycle-by-cycle bench model judges them.

// File: rtl/dct_pkg.sv
package dct_pkg;
    typedef enum logic {
        SRC_HALF    = 1'b0,
        SRC_CASCADE = 1'b1
    } dct_src_e;
endpackage

// File: rtl/dct_tick_gen.sv
module dct_tick_gen
    import dct_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  dct_src_e src,
    input  logic     cascade_tick,
    output logic     tick
);
    typedef struct packed {
        logic half;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.half = ~st_q.half;
        tick      = (src == SRC_CASCADE) ? cascade_tick : st_q.half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dct_ctrl_reg.sv
module dct_ctrl_reg
    import dct_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CNT_W+2:0]     wr_data,
    output logic                 en,
    output logic                 run,
    output dct_src_e             src,
    output logic                 wr_accept,
    output logic [CNT_W-1:0]     wr_cnt,
    output logic [CNT_W-1:0]     reload
);
    localparam int EN_POS  = CNT_W + 2;
    localparam int RUN_POS = CNT_W + 1;
    localparam int SRC_POS = CNT_W;

    typedef struct packed {
        logic             en;
        logic             run;
        dct_src_e         src;
        logic [CNT_W-1:0] reload;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        wr_accept = wr_en & st_q.en;
        wr_cnt    = wr_data[CNT_W-1:0];
        if (wr_accept) begin
            st_d.en  = wr_data[EN_POS];
            st_d.run = wr_data[RUN_POS];
            st_d.src = dct_src_e'(wr_data[SRC_POS]);
            if (wr_cnt != '0) st_d.reload = wr_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en     <= 1'b1;
            st_q.run    <= 1'b0;
            st_q.src    <= SRC_HALF;
            st_q.reload <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en     = st_q.en;
    assign run    = st_q.run;
    assign src    = st_q.src;
    assign reload = st_q.reload;
endmodule

// File: rtl/dct_count_core.sv
module dct_count_core #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_accept,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [CNT_W-1:0] reload,
    input  logic             active,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_accept) begin
            st_d.cnt = wr_cnt;
        end else if (active && tick && (st_q.cnt != '0)) begin
            if (st_q.cnt == ONE) begin
                st_d.cnt = reload;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign irq = st_q.irq;
endmodule

// File: rtl/cascade_down_timer.sv
module cascade_down_timer
    import dct_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W+2:0] wr_data,
    input  logic             cascade_tick,
    output logic [CNT_W+2:0] rd_data,
    output logic             irq
);
    localparam int WORD_W = CNT_W + 3;

    logic             en, run, wr_accept, tick;
    dct_src_e         src;
    logic [CNT_W-1:0] wr_cnt, reload, cnt;

    dct_ctrl_reg #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .en(en), .run(run), .src(src), .wr_accept(wr_accept),
        .wr_cnt(wr_cnt), .reload(reload)
    );

    dct_tick_gen u_tick (
        .clk(clk), .rst_n(rst_n), .src(src),
        .cascade_tick(cascade_tick), .tick(tick)
    );

    dct_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept), .wr_cnt(wr_cnt),
        .reload(reload), .active(en & run), .tick(tick),
        .cnt(cnt), .irq(irq)
    );

    always_comb begin
        rd_data = '0;
        if (en) rd_data = {en, run, src, cnt};
    end

    logic unused_w;
    assign unused_w = (WORD_W == 0);
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             run,
    input logic             wr_accept,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             irq,
    input logic [CNT_W+2:0] rd_data
);
    assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_accept) |=> $stable(cnt));

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == reload));

    assert_zero_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !wr_accept) |=> (cnt == '0 && !irq));

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cnt) == CNT_W'(1) && $past(en) && $past(run)));

    assert_one_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !en);

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (rd_data == '0 && !irq));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> !irq);
endmodule

bind cascade_down_timer dct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run), .wr_accept(wr_accept),
    .cnt(cnt), .reload(reload), .irq(irq), .rd_data(rd_data)
);

// File: tb/cascade_down_timer_tb.sv
module cascade_down_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        cascade_tick = 1'b0;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R11";
    int cyc_idx = 0;

    // bench model state
    bit          m_en = 1'b1, m_run = 1'b0, m_src = 1'b0, m_half = 1'b0, m_irq = 1'b0;
    logic [12:0] m_cnt = '0, m_reload = '0;

    always #2 clk = ~clk;

    cascade_down_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cascade_tick(cascade_tick), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [15:0] exp_rd();
        return m_en ? {1'b1, m_run, m_src, m_cnt} : 16'h0000;
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_step();
        bit tk, nirq;
        tk = m_src ? cascade_tick : m_half;
        nirq = 1'b0;
        if (wr_en && m_en) begin
            m_en  = wr_data[15];
            m_run = wr_data[14];
            m_src = wr_data[13];
            if (wr_data[12:0] != 0) m_reload = wr_data[12:0];
            m_cnt = wr_data[12:0];
        end else if (m_en && m_run && tk && m_cnt != 0) begin
            if (m_cnt == 1) begin
                m_cnt = m_reload;
                nirq = 1'b1;
            end else begin
                m_cnt = m_cnt - 1'b1;
            end
        end
        m_half = !m_half;
        m_irq = nirq;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        cyc_idx++;
        #1;
        check(rd_data, exp_rd(), cur_req);
        check({15'd0, irq}, {15'd0, m_irq}, cur_req);
    endtask

    task automatic wr(input logic [15:0] v);
        wr_en = 1'b1;
        wr_data = v;
        cyc();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check(rd_data, 16'h8000, "R1");
        check({15'd0, irq}, 16'h0000, "R1");

        // R2 / R7: 0xC008 -> one pulse every 16 clocks
        begin
            int last = -1;
            bit prev = 1'b0;
            int pulses = 0;
            cur_req = "R2";
            wr(16'hC008);
            repeat (70) begin
                cyc();
                if (irq) begin
                    pulses++;
                    if (last >= 0) check(16'(cyc_idx - last), 16'd16, "R2");
                    last = cyc_idx;
                    // R5: count back at the reload value
                    check({3'b0, rd_data[12:0]}, 16'd8, "R5");
                end
                if (irq && prev) check(16'd2, 16'd1, "R7");
                prev = irq;
            end
            check(16'(pulses >= 4), 16'd1, "R2");
        end

        // R3: run off freezes the count
        cur_req = "R3";
        wr(16'h8005);
        repeat (12) cyc();
        check(rd_data, 16'h8005, "R3");

        // R6: zero written after counting starts parks the counter
        cur_req = "R6";
        wr(16'hC00A);
        repeat (7) cyc();
        wr(16'hC000);
        begin
            bit seen = 1'b0;
            repeat (40) begin
                cyc();
                if (irq) seen = 1'b1;
            end
            check({15'd0, seen}, 16'd0, "R6");
            check(rd_data, 16'hC000, "R6");
        end

        // R4: cascade source, ticks only on cascade_tick
        cur_req = "R4";
        wr(16'hE003);
        cascade_tick = 1'b0;
        repeat (10) cyc();
        check(rd_data, 16'hE003, "R4");
        cascade_tick = 1'b1; cyc();
        cascade_tick = 1'b0; cyc();
        cascade_tick = 1'b1; cyc();
        cascade_tick = 1'b1; cyc();
        cascade_tick = 1'b0;
        check({15'd0, irq}, 16'd1, "R4");
        check(rd_data, 16'hE003, "R5");
        cyc();
        check({15'd0, irq}, 16'd0, "R7");

        // R10: write collides with an expiring tick
        cur_req = "R10";
        wr(16'hE001);
        cascade_tick = 1'b1;
        cyc();
        check({15'd0, irq}, 16'd1, "R10");
        cyc();
        wr(16'hE004);
        check({15'd0, irq}, 16'd0, "R10");
        check(rd_data, 16'hE004, "R10");

        // R11: random writes and tick patterns against the model
        cur_req = "R11";
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 400; i++) begin
            cascade_tick = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 9) == 0) begin
                logic [15:0] v;
                v = 16'($urandom());
                v[15] = 1'b1;
                if ($urandom_range(0, 1) == 1) v[12:0] = 13'($urandom_range(0, 6));
                wr(v);
            end else begin
                cyc();
            end
        end
        cascade_tick = 1'b0;

        // R8 / R9: turn off, then try to turn back on
        cur_req = "R8";
        wr(16'hC005);
        wr(16'h4005);
        check(rd_data, 16'h0000, "R8");
        wr(16'hC008);
        check(rd_data, 16'h0000, "R8");
        cur_req = "R9";
        begin
            bit seen = 1'b0;
            repeat (50) begin
                cyc();
                if (irq) seen = 1'b1;
            end
            check({15'd0, seen}, 16'd0, "R9");
            check(rd_data, 16'h0000, "R9");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule